// File: doc/BRIEF.md
# Extension Register Byte Load/Store Unit

This unit executes four byte-wide memory instructions for a 32-bit media extension register file. Each instruction forms an effective address by adding a sign-extended 8-bit displacement to a general-purpose base register. It then either fetches one byte from memory into a chosen byte lane of an extension register, or sends one byte taken from a chosen lane to memory. Two of the four instructions also write the effective address back into the base register, so a loop can walk through a byte stream without a separate add.

The unit takes one instruction at a time. It reads both register files through combinational read ports in the cycle it accepts the instruction. It issues one request on a byte memory port. It commits its register writes in a single cycle with a `done` pulse, and keeps `busy` high from the cycle after acceptance until that commit cycle.

Top module: `xreg_byte_lsu`

## Requirements
- R1: The function code is `insn[5:0]`. 0x22 is a load, 0x23 a store, 0x24 a load with base update and 0x25 a store with base update. Any other code raises no memory request and causes no register write.
- R2: The base register index is `insn[25:21]`, the extension register index is `insn[9:6]`, the lane pattern is `insn[20:18]` and the displacement is `insn[17:10]`. `mem_addr` equals the base value plus the displacement sign-extended from 8 bits, modulo 2^32.
- R3: A store with pattern p (0 to 3) drives `mem_we`=1 and `mem_wdata` equal to bits [8p+7:8p] of the extension register.
- R4: A load with pattern p (0 to 3) writes the extension register with the returned byte in bits [8p+7:8p]. The other three lanes keep their previous value.
- R5: The base-update variants write the effective address into the base register in the commit cycle. The memory access uses that same address.
- R6: Patterns 4 to 7 make both loads and stores a no-op: no memory request, no register write and no `done`.
- R7: Extension register 0 reads as zero, so a store from it sends 0x00. It is never written (`xr_we` is never high with `xr_waddr`=0).
- R8: General register 0 is never written by a base update.
- R9: `mem_req` rises the cycle after acceptance and holds with stable address and data until the cycle `mem_gnt` is high. A store commits (`done`, writes) in the cycle after the grant. A load waits for `mem_rvalid`, starting the cycle after the grant, and commits in the cycle after it.
- R10: After reset `busy`, `mem_req`, `done`, `gpr_we` and `xr_we` are all low.
- R11: `insn_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| busy | output | 1 | An accepted instruction is in flight |
| done | output | 1 | One-cycle pulse in the commit cycle |
| gpr_raddr | output | 5 | General register read index |
| gpr_rdata | input | 32 | General register read data (combinational) |
| gpr_we | output | 1 | General register write enable |
| gpr_waddr | output | 5 | General register write index |
| gpr_wdata | output | 32 | General register write data |
| xr_raddr | output | 4 | Extension register read index |
| xr_rdata | input | 32 | Extension register read data (combinational) |
| xr_we | output | 1 | Extension register write enable |
| xr_waddr | output | 4 | Extension register write index |
| xr_wdata | output | 32 | Extension register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read byte valid |
| mem_rdata | input | 8 | Read byte |

## Verification
An instruction presented in cycle c is accepted at the end of c, and `mem_req` is visible in c+1. A store's writes and `done` appear exactly one cycle after the cycle carrying `mem_gnt`. A load's writes appear one cycle after the cycle carrying `mem_rvalid`. The bench's memory responder samples every output at the falling edge and records the cycle number of acceptance, request start, grant, read response and `done`. Each test then compares these distances with the counts above, for several grant waits and read latencies. No-op cases run for a fixed window and confirm that no request, write or `done` appeared in it.

// File: rtl/xbl_pkg.sv
package xbl_pkg;
    localparam int XLEN       = 32;
    localparam int BYTE_W     = 8;
    localparam int NLANES     = XLEN / BYTE_W;
    localparam int LANE_SEL_W = $clog2(NLANES);
    localparam int GR_IDX_W   = 5;
    localparam int XR_IDX_W   = 4;
    localparam int FUNC_W     = 6;
    localparam int PAT_W      = 3;

    localparam logic [FUNC_W-1:0] FN_LD    = 6'h22;
    localparam logic [FUNC_W-1:0] FN_ST    = 6'h23;
    localparam logic [FUNC_W-1:0] FN_LD_UP = 6'h24;
    localparam logic [FUNC_W-1:0] FN_ST_UP = 6'h25;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ    = 2'd1,
        ST_WAIT   = 2'd2,
        ST_COMMIT = 2'd3
    } xbl_state_e;

    typedef struct packed {
        logic                  legal;
        logic                  is_load;
        logic                  post_mod;
        logic [GR_IDX_W-1:0]   gr_idx;
        logic [XR_IDX_W-1:0]   xr_idx;
        logic [BYTE_W-1:0]     disp;
        logic [LANE_SEL_W-1:0] lane;
    } xbl_dec_t;

    typedef struct packed {
        xbl_state_e            st;
        logic                  is_load;
        logic                  post_mod;
        logic [GR_IDX_W-1:0]   gr_idx;
        logic [XR_IDX_W-1:0]   xr_idx;
        logic [LANE_SEL_W-1:0] lane;
        logic [XLEN-1:0]       ea;
        logic [XLEN-1:0]       xr_word;
        logic [BYTE_W-1:0]     st_byte;
    } xbl_ctx_t;
endpackage

// File: rtl/xbl_decode.sv
module xbl_decode
    import xbl_pkg::*;
(
    input  logic [XLEN-1:0] insn,
    output xbl_dec_t        dec
);
    logic [FUNC_W-1:0] func;
    logic [PAT_W-1:0]  pat;
    logic              fn_hit;
    logic              unused_hi;

    assign func      = insn[FUNC_W-1:0];
    assign pat       = insn[20:18];
    assign unused_hi = ^insn[31:26];

    always_comb begin
        dec          = '0;
        fn_hit       = 1'b0;
        dec.gr_idx   = insn[25:21];
        dec.xr_idx   = insn[9:6];
        dec.disp     = insn[17:10];
        dec.lane     = pat[LANE_SEL_W-1:0];
        unique case (func)
            FN_LD:    begin fn_hit = 1'b1; dec.is_load = 1'b1; end
            FN_ST:    begin fn_hit = 1'b1; end
            FN_LD_UP: begin fn_hit = 1'b1; dec.is_load = 1'b1; dec.post_mod = 1'b1; end
            FN_ST_UP: begin fn_hit = 1'b1; dec.post_mod = 1'b1; end
            default:  fn_hit = 1'b0;
        endcase
        dec.legal = fn_hit && (pat < PAT_W'(NLANES));
    end
endmodule

// File: rtl/xbl_agen.sv
module xbl_agen
    import xbl_pkg::*;
(
    input  logic [XLEN-1:0]   base,
    input  logic [BYTE_W-1:0] disp,
    output logic [XLEN-1:0]   ea
);
    logic [XLEN-1:0] disp_ext;

    assign disp_ext = {{(XLEN-BYTE_W){disp[BYTE_W-1]}}, disp};
    assign ea       = base + disp_ext;
endmodule

// File: rtl/xbl_lane.sv
module xbl_lane
    import xbl_pkg::*;
(
    input  logic [XLEN-1:0]       ext_src,
    input  logic [LANE_SEL_W-1:0] ext_sel,
    output logic [BYTE_W-1:0]     ext_byte,
    input  logic [XLEN-1:0]       ins_src,
    input  logic [LANE_SEL_W-1:0] ins_sel,
    input  logic [BYTE_W-1:0]     ins_byte,
    output logic [XLEN-1:0]       ins_word
);
    logic [BYTE_W-1:0] picked [NLANES];

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        assign picked[l] = (ext_sel == LANE_SEL_W'(l)) ? ext_src[l*BYTE_W +: BYTE_W] : '0;
        assign ins_word[l*BYTE_W +: BYTE_W] =
            (ins_sel == LANE_SEL_W'(l)) ? ins_byte : ins_src[l*BYTE_W +: BYTE_W];
    end

    always_comb begin
        ext_byte = '0;
        for (int l = 0; l < NLANES; l++) begin
            ext_byte = ext_byte | picked[l];
        end
    end
endmodule

// File: rtl/xreg_byte_lsu.sv
module xreg_byte_lsu
    import xbl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                insn_valid,
    input  logic [XLEN-1:0]     insn,
    output logic                busy,
    output logic                done,
    output logic [GR_IDX_W-1:0] gpr_raddr,
    input  logic [XLEN-1:0]     gpr_rdata,
    output logic                gpr_we,
    output logic [GR_IDX_W-1:0] gpr_waddr,
    output logic [XLEN-1:0]     gpr_wdata,
    output logic [XR_IDX_W-1:0] xr_raddr,
    input  logic [XLEN-1:0]     xr_rdata,
    output logic                xr_we,
    output logic [XR_IDX_W-1:0] xr_waddr,
    output logic [XLEN-1:0]     xr_wdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [XLEN-1:0]     mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic                mem_gnt,
    input  logic                mem_rvalid,
    input  logic [BYTE_W-1:0]   mem_rdata
);
    xbl_dec_t          dec;
    xbl_ctx_t          ctx_d, ctx_q;
    logic [XLEN-1:0]   ea_new;
    logic [XLEN-1:0]   xr_cur;
    logic [BYTE_W-1:0] st_byte_new;
    logic [XLEN-1:0]   merged;

    xbl_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    xbl_agen u_agen (
        .base (gpr_rdata),
        .disp (dec.disp),
        .ea   (ea_new)
    );

    assign xr_cur = (dec.xr_idx == '0) ? '0 : xr_rdata;

    xbl_lane u_lane (
        .ext_src  (xr_cur),
        .ext_sel  (dec.lane),
        .ext_byte (st_byte_new),
        .ins_src  (ctx_q.xr_word),
        .ins_sel  (ctx_q.lane),
        .ins_byte (mem_rdata),
        .ins_word (merged)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (insn_valid && dec.legal) begin
                    ctx_d.st       = ST_REQ;
                    ctx_d.is_load  = dec.is_load;
                    ctx_d.post_mod = dec.post_mod;
                    ctx_d.gr_idx   = dec.gr_idx;
                    ctx_d.xr_idx   = dec.xr_idx;
                    ctx_d.lane     = dec.lane;
                    ctx_d.ea       = ea_new;
                    ctx_d.xr_word  = xr_cur;
                    ctx_d.st_byte  = st_byte_new;
                end
            end
            ST_REQ: begin
                if (mem_gnt) begin
                    ctx_d.st = ctx_q.is_load ? ST_WAIT : ST_COMMIT;
                end
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    ctx_d.xr_word = merged;
                    ctx_d.st      = ST_COMMIT;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign gpr_raddr = dec.gr_idx;
    assign xr_raddr  = dec.xr_idx;

    assign busy      = (ctx_q.st != ST_IDLE);
    assign done      = (ctx_q.st == ST_COMMIT);

    assign mem_req   = (ctx_q.st == ST_REQ);
    assign mem_we    = !ctx_q.is_load;
    assign mem_addr  = ctx_q.ea;
    assign mem_wdata = ctx_q.st_byte;

    assign gpr_we    = done && ctx_q.post_mod && (ctx_q.gr_idx != '0);
    assign gpr_waddr = ctx_q.gr_idx;
    assign gpr_wdata = ctx_q.ea;

    assign xr_we     = done && ctx_q.is_load && (ctx_q.xr_idx != '0);
    assign xr_waddr  = ctx_q.xr_idx;
    assign xr_wdata  = ctx_q.xr_word;
endmodule

// File: rtl/xbl_checker.sv
module xbl_checker
    import xbl_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                done,
    input logic                gpr_we,
    input logic [GR_IDX_W-1:0] gpr_waddr,
    input logic                xr_we,
    input logic [XR_IDX_W-1:0] xr_waddr,
    input logic                mem_req,
    input logic                mem_we,
    input logic [XLEN-1:0]     mem_addr,
    input logic [BYTE_W-1:0]   mem_wdata,
    input logic                mem_gnt
);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req);

    // R9
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req);

    // R7
    xr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xr_we |-> (xr_waddr != '0));

    // R8
    gpr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we |-> (gpr_waddr != '0));

    // R9
    write_in_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gpr_we || xr_we) |-> (done && !mem_req));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));
endmodule

bind xreg_byte_lsu xbl_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .gpr_we    (gpr_we),
    .gpr_waddr (gpr_waddr),
    .xr_we     (xr_we),
    .xr_waddr  (xr_waddr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt)
);

// File: tb/xreg_byte_lsu_test.sv
`timescale 1ns/1ps
module xreg_byte_lsu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic        busy, done;
    logic [4:0]  gpr_raddr, gpr_waddr;
    logic [31:0] gpr_rdata, gpr_wdata;
    logic        gpr_we;
    logic [3:0]  xr_raddr, xr_waddr;
    logic [31:0] xr_rdata, xr_wdata;
    logic        xr_we;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;

    always #2.5 clk = ~clk;

    xreg_byte_lsu uut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .busy(busy), .done(done),
        .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata), .gpr_we(gpr_we),
        .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
        .xr_raddr(xr_raddr), .xr_rdata(xr_rdata), .xr_we(xr_we),
        .xr_waddr(xr_waddr), .xr_wdata(xr_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    logic [31:0] gpr_m [32];
    logic [31:0] xr_m  [16];
    logic [7:0]  mem_m [256];

    assign gpr_rdata = gpr_m[gpr_raddr];
    assign xr_rdata  = xr_m[xr_raddr];

    int n_vec = 0;
    int n_bad = 0;

    int cyc = 0, valid_cyc = 0, req_cyc = 0, gnt_cyc = 0, rv_cyc = 0, done_cyc = 0;
    int req_cnt = 0, done_cnt = 0, gpr_wr_cnt = 0, xr_wr_cnt = 0, mem_wr_cnt = 0;
    int gnt_wait = 0, rd_lat = 0, gnt_left = 0, rd_left = -1;
    logic        req_prev = 1'b0;
    logic        pend = 1'b0, pend_we = 1'b0;
    logic [31:0] pend_addr = '0, last_addr = '0;
    logic [7:0]  pend_data = '0;

    // Memory responder and monitor, all on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (insn_valid && !busy) valid_cyc = cyc;
        if (mem_rvalid) mem_rvalid = 1'b0;
        if (mem_gnt) begin
            mem_gnt = 1'b0;
            if (pend_we) begin
                mem_m[pend_addr[7:0]] = pend_data;
                mem_wr_cnt++;
            end else begin
                rd_left = rd_lat;
            end
            pend = 1'b0;
        end
        if (rd_left == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem_m[pend_addr[7:0]];
            rv_cyc     = cyc;
            rd_left    = -1;
        end else if (rd_left > 0) begin
            rd_left--;
        end
        if (mem_req && !req_prev) begin
            req_cnt++;
            req_cyc  = cyc;
            gnt_left = gnt_wait;
        end
        if (mem_req) begin
            if (gnt_left == 0) begin
                mem_gnt   = 1'b1;
                pend      = 1'b1;
                pend_we   = mem_we;
                pend_addr = mem_addr;
                pend_data = mem_wdata;
                last_addr = mem_addr;
                gnt_cyc   = cyc;
            end else begin
                gnt_left--;
            end
        end
        req_prev = mem_req;
        if (done) begin
            done_cnt++;
            done_cyc = cyc;
        end
        if (gpr_we) begin
            gpr_m[gpr_waddr] = gpr_wdata;
            gpr_wr_cnt++;
        end
        if (xr_we) begin
            xr_m[xr_waddr] = xr_wdata;
            xr_wr_cnt++;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [5:0] fn, input logic [4:0] gr,
                                        input logic [2:0] pat, input logic [7:0] disp,
                                        input logic [3:0] xr);
        return {6'd0, gr, pat, disp, xr, fn};
    endfunction

    function automatic logic [31:0] sx(input logic [7:0] d);
        return {{24{d[7]}}, d};
    endfunction

    task automatic issue(input logic [31:0] w);
        @(posedge clk); #1;
        insn = w;
        insn_valid = 1'b1;
        @(posedge clk); #1;
        insn_valid = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        int start;
        start = done_cnt;
        for (int i = 0; i < 60 && done_cnt == start; i++) @(posedge clk);
        ok = (done_cnt != start);
        @(posedge clk);
    endtask

    task automatic t_reset();
        check("R10", "busy", {31'd0, busy}, 32'd0);
        check("R10", "mem_req", {31'd0, mem_req}, 32'd0);
        check("R10", "done", {31'd0, done}, 32'd0);
        check("R10", "gpr_we/xr_we", {30'd0, gpr_we, xr_we}, 32'd0);
    endtask

    task automatic t_store_lanes();
        for (int p = 0; p < 4; p++) begin
            logic [7:0]  d;
            logic [31:0] ea;
            bit ok;
            d = (p % 2 == 0) ? 8'hFC : 8'h13;
            gpr_m[3] = 32'h0000_1040 + 32'(p * 16);
            xr_m[5]  = 32'hDDCC_BBAA;
            ea = gpr_m[3] + sx(d);
            mem_m[ea[7:0]] = 8'h00;
            gnt_wait = p;
            issue(enc(6'h23, 5'd3, 3'(p), d, 4'd5));
            wait_done(ok);
            check("R3", "store done", {31'd0, ok}, 32'd1);
            check("R2", "store addr", last_addr, ea);
            check("R3", "store byte", {24'd0, mem_m[ea[7:0]]}, {24'd0, xr_m[5][p*8 +: 8]});
            check("R1", "store base kept", gpr_m[3], 32'h0000_1040 + 32'(p * 16));
            check("R9", "req after accept", 32'(req_cyc - valid_cyc), 32'd1);
            check("R9", "store commit after grant", 32'(done_cyc - gnt_cyc), 32'd1);
        end
    endtask

    task automatic t_store_post();
        logic [31:0] ea;
        bit ok;
        gpr_m[9] = 32'h2000_0010;
        xr_m[2]  = 32'h4433_2211;
        ea = 32'h2000_0010 + sx(8'h80);
        gnt_wait = 1;
        issue(enc(6'h25, 5'd9, 3'd1, 8'h80, 4'd2));
        wait_done(ok);
        check("R5", "post store base", gpr_m[9], ea);
        check("R5", "post store addr", last_addr, ea);
        check("R3", "post store byte", {24'd0, mem_m[ea[7:0]]}, 32'h22);
    endtask

    task automatic t_load_lanes();
        for (int p = 0; p < 4; p++) begin
            logic [31:0] ea, exp;
            bit ok;
            gpr_m[4] = 32'h0000_0300;
            xr_m[7]  = 32'h1122_3344;
            ea = gpr_m[4] + sx(8'(p * 3 + 1));
            mem_m[ea[7:0]] = 8'h5A + 8'(p);
            exp = 32'h1122_3344;
            exp[p*8 +: 8] = 8'h5A + 8'(p);
            gnt_wait = 0;
            rd_lat = p;
            issue(enc(6'h22, 5'd4, 3'(p), 8'(p * 3 + 1), 4'd7));
            wait_done(ok);
            check("R4", "load merged", xr_m[7], exp);
            check("R2", "load addr", last_addr, ea);
            check("R9", "load commit after rvalid", 32'(done_cyc - rv_cyc), 32'd1);
        end
    endtask

    task automatic t_load_post();
        logic [31:0] ea;
        bit ok;
        gpr_m[12] = 32'hFFFF_FFF0;
        xr_m[3]   = 32'h0;
        ea = 32'hFFFF_FFF0 + sx(8'h20);
        mem_m[ea[7:0]] = 8'hC3;
        gnt_wait = 2;
        rd_lat = 3;
        issue(enc(6'h24, 5'd12, 3'd3, 8'h20, 4'd3));
        @(negedge clk);
        check("R9", "busy during load", {31'd0, busy}, 32'd1);
        wait_done(ok);
        check("R5", "post load base wraps", gpr_m[12], ea);
        check("R4", "post load lane3", xr_m[3], 32'hC300_0000);
    endtask

    task automatic t_reserved();
        int r0, d0;
        r0 = req_cnt; d0 = done_cnt;
        gpr_m[6] = 32'h100;
        xr_m[6]  = 32'h600D_F00D;
        issue(enc(6'h25, 5'd6, 3'd5, 8'h04, 4'd6));
        repeat (6) @(posedge clk);
        issue(enc(6'h24, 5'd6, 3'd7, 8'h04, 4'd6));
        repeat (6) @(posedge clk);
        check("R6", "reserved no request", 32'(req_cnt - r0), 32'd0);
        check("R6", "reserved no done", 32'(done_cnt - d0), 32'd0);
        check("R6", "reserved base kept", gpr_m[6], 32'h100);
        check("R6", "reserved xr kept", xr_m[6], 32'h600D_F00D);
    endtask

    task automatic t_bad_func();
        int r0, g0, x0;
        r0 = req_cnt; g0 = gpr_wr_cnt; x0 = xr_wr_cnt;
        issue(enc(6'h26, 5'd6, 3'd0, 8'h04, 4'd6));
        repeat (6) @(posedge clk);
        issue(enc(6'h21, 5'd6, 3'd0, 8'h04, 4'd6));
        repeat (6) @(posedge clk);
        check("R1", "unknown code no request", 32'(req_cnt - r0), 32'd0);
        check("R1", "unknown code no writes", 32'(gpr_wr_cnt - g0 + xr_wr_cnt - x0), 32'd0);
    endtask

    task automatic t_zero_regs();
        bit ok;
        int x0, g0;
        gnt_wait = 0;
        rd_lat = 0;
        gpr_m[5] = 32'h40;
        mem_m[8'h42] = 8'hEE;
        issue(enc(6'h23, 5'd5, 3'd2, 8'h02, 4'd0));
        wait_done(ok);
        check("R7", "store from xr0", {24'd0, mem_m[8'h42]}, 32'd0);
        x0 = xr_wr_cnt;
        mem_m[8'h43] = 8'h77;
        issue(enc(6'h22, 5'd5, 3'd0, 8'h03, 4'd0));
        wait_done(ok);
        check("R7", "load to xr0 no write", 32'(xr_wr_cnt - x0), 32'd0);
        g0 = gpr_wr_cnt;
        xr_m[1] = 32'h0000_00B1;
        issue(enc(6'h25, 5'd0, 3'd0, 8'hF8, 4'd1));
        wait_done(ok);
        check("R8", "gpr0 no write", 32'(gpr_wr_cnt - g0), 32'd0);
        check("R8", "gpr0 addr", last_addr, 32'hFFFF_FFF8);
    endtask

    task automatic t_busy_ignore();
        bit ok;
        int r0;
        r0 = req_cnt;
        gnt_wait = 4;
        gpr_m[7] = 32'h80;
        xr_m[8]  = 32'h0000_0099;
        mem_m[8'h90] = 8'h00;
        issue(enc(6'h23, 5'd7, 3'd0, 8'h01, 4'd8));
        issue(enc(6'h23, 5'd7, 3'd0, 8'h10, 4'd8));
        wait_done(ok);
        repeat (8) @(posedge clk);
        check("R11", "second insn ignored", 32'(req_cnt - r0), 32'd1);
        check("R11", "ignored insn no write", {24'd0, mem_m[8'h90]}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) gpr_m[i] = '0;
        for (int i = 0; i < 16; i++) xr_m[i] = 32'h0101_0101 * 32'(i);
        xr_m[0] = 32'hAA55_AA55;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'(i);
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_store_lanes();
        t_store_post();
        t_load_lanes();
        t_load_post();
        t_reserved();
        t_bad_func();
        t_zero_regs();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule